// File: doc/BRIEF.md
# MSI Table Entry Address Generator

When a device sends a message-signalled interrupt, the translation unit must fetch one entry from a per-device MSI table before it can redirect the write. This block takes the MSI write's guest physical address, the device's MSI address mask and the table's root page number. It returns either the byte address of the table entry to fetch or a load fault. The page-number bits that the mask selects are packed, from the least significant bit upward, into a dense interrupt file number. Each table entry occupies sixteen bytes, so that number is scaled by sixteen. The result is then merged with the table base.

The base is not compared against a fixed table size. Any offset bit that lands on a set base bit is treated as out of range and reported as a fault. Requests enter on a valid/ready port and results leave on a valid/ready port through a single register stage. A new request is taken whenever the output register is empty or is being drained in the same cycle. A result that is not accepted stays on the outputs unchanged for as long as ready is low. The mask and root page number travel with the request and are captured when it is accepted.

Top module: `msi_pte_addr_gen`

## Requirements
- R1: The interrupt file number is formed from bits [63:12] of `req_gpa` (the guest page number). Page-number bit i is kept when `req_mask[i]` is 1. The kept bits are placed in the file number in increasing order of i, starting at file-number bit 0, and the unused upper bits are 0.
- R2: The entry byte offset is the file number shifted left by 4 (multiplied by 16). It is zero-extended to 64 bits.
- R3: The table base is `req_root` shifted left by 12, zero-extended to 64 bits.
- R4: When the offset and the base share any set bit, the result is a fault. In that case `rsp_fault` is 1, `rsp_cause` is 261 and `rsp_addr` is 0.
- R5: When the offset and the base share no set bit, `rsp_fault` is 0, `rsp_cause` is 0 and `rsp_addr` is the base ORed with the offset.
- R6: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. A request accepted at a clock edge is presented on the outputs with `rsp_valid` high right after that edge. Back-to-back requests are accepted at full rate while `rsp_ready` stays high.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_addr`, `rsp_fault` and `rsp_cause` hold their values.
- R8: Changes to `req_gpa`, `req_mask` or `req_root` after a request has been accepted have no effect on that request's result.
- R9: While `rst_n` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R10: With `req_mask` all zero, the result is never a fault and `rsp_addr` equals the base.
- R11: Bits [11:0] of `req_gpa` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_gpa | input | 64 | Guest physical address of the MSI write |
| req_mask | input | 52 | Mask selecting the page-number bits that form the file number |
| req_root | input | 44 | Root page number of the MSI table |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_addr | output | 64 | Entry fetch address (0 on fault) |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 12 | Fault cause: 261 on fault, 0 otherwise |

## Verification
The bench uses sparse masks with gaps, masks that reach the top page-number bit, and an all-zero mask. A packing that kept the original bit positions, or reversed the order, would give wrong addresses in these cases. Offsets that land exactly on one set base bit, and offsets placed just beside it, separate a true overlap check from a plain size compare or a missing check. In both the faulting and the clean case, the fault flag, the cause and the zeroed address are all checked. Back-pressure stretches hold a result while new, different request fields are driven. This exposes an output register that reloads while stalled, or a mask and root that are read late. A ready signal that ignores the drain path is caught by the back-to-back requests.

// File: rtl/msi_pte_pkg.sv
package msi_pte_pkg;

  // Default geometry of the address generator.
  localparam int unsigned ADDR_W_DEF      = 64;  // guest and fetch address width
  localparam int unsigned PAGE_SHIFT_DEF  = 12;  // page offset bits
  localparam int unsigned ROOT_W_DEF      = 44;  // table root page number width
  localparam int unsigned ENTRY_SHIFT_DEF = 4;   // log2 of entry size in bytes
  localparam int unsigned CAUSE_W         = 12;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE          = 12'd0,
    CAUSE_MSI_LOAD_FLT  = 12'd261
  } cause_e;

endpackage

// File: rtl/msi_pn_extract.sv
// Parallel bit extract: packs the page-number bits chosen by the mask
// densely into the low end of the file number (R1).
module msi_pn_extract #(
  parameter int unsigned PN_W = 52
) (
  input  logic [PN_W-1:0] pn_i,
  input  logic [PN_W-1:0] mask_i,
  output logic [PN_W-1:0] ifn_o
);
  localparam int unsigned IDX_W = $clog2(PN_W + 1);

  logic [IDX_W-1:0] idx;

  always_comb begin
    ifn_o = '0;
    idx   = '0;
    for (int i = 0; i < PN_W; i++) begin
      if (mask_i[i]) begin
        ifn_o[idx] = pn_i[i];
        idx        = idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_pte_locate.sv
// Scales the file number to a byte offset, forms the table base and
// checks the two for overlap (R2, R3, R4, R5).
module msi_pte_locate
  import msi_pte_pkg::*;
#(
  parameter int unsigned PN_W        = 52,
  parameter int unsigned ROOT_W      = 44,
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned PAGE_SHIFT  = 12,
  parameter int unsigned ENTRY_SHIFT = 4
) (
  input  logic [PN_W-1:0]    ifn_i,
  input  logic [ROOT_W-1:0]  root_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] offs_w;
  logic              clash;

  assign base_w = ADDR_W'(root_i) << PAGE_SHIFT;
  assign offs_w = ADDR_W'(ifn_i) << ENTRY_SHIFT;
  assign clash  = |(base_w & offs_w);

  always_comb begin
    if (clash) begin
      addr_o  = '0;
      fault_o = 1'b1;
      cause_o = CAUSE_MSI_LOAD_FLT;
    end else begin
      addr_o  = base_w | offs_w;
      fault_o = 1'b0;
      cause_o = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/msi_pte_stage.sv
// One-entry valid/ready register slice (R6, R7, R9).
module msi_pte_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/msi_pte_addr_gen.sv
module msi_pte_addr_gen
  import msi_pte_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned PAGE_SHIFT  = PAGE_SHIFT_DEF,
  parameter int unsigned ROOT_W      = ROOT_W_DEF,
  parameter int unsigned ENTRY_SHIFT = ENTRY_SHIFT_DEF,
  localparam int unsigned PN_W       = ADDR_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_gpa,
  input  logic [PN_W-1:0]    req_mask,
  input  logic [ROOT_W-1:0]  req_root,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause
);
  localparam int unsigned RES_W = ADDR_W + 1 + CAUSE_W;

  logic [PN_W-1:0]    ifn;
  logic [ADDR_W-1:0]  nxt_addr;
  logic               nxt_fault;
  logic [CAUSE_W-1:0] nxt_cause;
  logic [RES_W-1:0]   res_d;
  logic [RES_W-1:0]   res_q;

  // R1, R11: only the page number feeds the extract
  msi_pn_extract #(.PN_W(PN_W)) u_extract (
    .pn_i   (req_gpa[ADDR_W-1:PAGE_SHIFT]),
    .mask_i (req_mask),
    .ifn_o  (ifn)
  );

  msi_pte_locate #(
    .PN_W(PN_W), .ROOT_W(ROOT_W), .ADDR_W(ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_locate (
    .ifn_i   (ifn),
    .root_i  (req_root),
    .addr_o  (nxt_addr),
    .fault_o (nxt_fault),
    .cause_o (nxt_cause)
  );

  assign res_d = {nxt_addr, nxt_fault, nxt_cause};

  // R8: the result is captured at acceptance, so later field changes are moot
  msi_pte_stage #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (res_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (res_q)
  );

  assign rsp_addr  = res_q[RES_W-1 -: ADDR_W];
  assign rsp_fault = res_q[CAUSE_W];
  assign rsp_cause = res_q[CAUSE_W-1:0];
endmodule

// File: rtl/msi_pte_addr_gen_chk.sv
module msi_pte_addr_gen_chk
  import msi_pte_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ROOT_W     = 44,
  parameter int unsigned PN_W       = 52
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [PN_W-1:0]    req_mask,
  input logic [ROOT_W-1:0]  req_root,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [ADDR_W-1:0]  rsp_addr,
  input logic               rsp_fault,
  input logic [CAUSE_W-1:0] rsp_cause
);
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr)
      && $stable(rsp_fault) && $stable(rsp_cause));

  a_r6_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r6_ready_when_drain: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> req_ready);

  a_r4_fault_form: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == '0 && rsp_cause == CAUSE_MSI_LOAD_FLT);

  a_r5_clean_form: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == CAUSE_NONE && rsp_addr[3:0] == 4'd0);

  a_r10_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mask == '0 |=>
      !rsp_fault && rsp_addr == (ADDR_W'($past(req_root)) << PAGE_SHIFT));
endmodule

bind msi_pte_addr_gen msi_pte_addr_gen_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ROOT_W(ROOT_W), .PN_W(PN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .req_root(req_root), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause)
);

// File: tb/msi_pte_addr_gen_test.sv
module msi_pte_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_gpa = '0;
  logic [51:0] req_mask = '0;
  logic [43:0] req_root = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_addr;
  logic        rsp_fault;
  logic [11:0] rsp_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] q_addr[$];
  logic        q_fault[$];
  logic [11:0] q_cause[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  msi_pte_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_gpa(req_gpa), .req_mask(req_mask), .req_root(req_root),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  // Reference: walk mask from the top, shifting kept bits in at the bottom
  function automatic logic [63:0] ref_ifn(input logic [63:0] gpa, input logic [51:0] m);
    logic [63:0] r = '0;
    for (int i = 51; i >= 0; i--)
      if (m[i]) r = (r << 1) | 64'(gpa[i+12]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: compare at negedge, drive, check ready, update model at posedge
  task automatic step(input bit v, input logic [63:0] gpa, input logic [51:0] m,
                      input logic [43:0] root, input bit rdy, input string tag);
    bit exp_rdy;
    @(negedge clk);
    check({tag, " R6 valid"}, 64'(rsp_valid), 64'(q_addr.size() != 0));
    if (q_addr.size() != 0) begin
      check({q_tag[0], " addr"},  rsp_addr, q_addr[0]);
      check({q_tag[0], " fault"}, 64'(rsp_fault), 64'(q_fault[0]));
      check({q_tag[0], " cause"}, 64'(rsp_cause), 64'(q_cause[0]));
    end
    req_valid = v; req_gpa = gpa; req_mask = m; req_root = root; rsp_ready = rdy;
    exp_rdy = (q_addr.size() == 0) || rdy;
    #1;
    check({tag, " R6 ready"}, 64'(req_ready), 64'(exp_rdy));
    @(posedge clk);
    if (q_addr.size() != 0 && rdy) begin
      void'(q_addr.pop_front()); void'(q_fault.pop_front());
      void'(q_cause.pop_front()); void'(q_tag.pop_front());
    end
    if (v && exp_rdy) begin
      logic [63:0] base = 64'(root) << 12;
      logic [63:0] offs = ref_ifn(gpa, m) * 64'd16;
      bit f = (base & offs) != 0;
      q_addr.push_back(f ? 64'd0 : (base | offs));
      q_fault.push_back(f);
      q_cause.push_back(f ? 12'd261 : 12'd0);
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0, 1'b1, "idle R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset valid", 64'(rsp_valid), 64'd0);
    check("R9 reset ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    // R10 zero mask
    step(1, 64'hFFFF_FFFF_FFFF_F123, '0, 44'h123_4567_89AB, 1, "R10 zero mask");
    // R1 contiguous low mask, R5 clean merge
    step(1, 64'h0000_0000_000A_B000, 52'hFF, 44'h10_0000, 1, "R1 contiguous");
    // R1 sparse mask including top page bit
    step(1, 64'h8000_0100_0000_8000, (52'h1 << 51) | (52'h1 << 28) | (52'h1 << 3) | 52'h4,
         44'h8000_0000, 1, "R1 sparse");
    // R4 overlap on a single base bit; R3 base
    step(1, 64'h0000_0000_0010_0000, 52'h1FF, 44'h1, 1, "R4 overlap");
    // R5 adjacent, no overlap
    step(1, 64'h0000_0000_0010_0000, 52'h1FF, 44'h2, 1, "R5 adjacent");
    // R2 full mask, R4 wide overlap
    step(1, 64'hFFFF_FFFF_FFFF_F000, {52{1'b1}}, 44'hFFF_FFFF_FFFF, 1, "R2 R4 full");
    // R11 low bits ignored
    step(1, 64'h0000_0000_0003_4FFF, 52'h3F, 44'h40, 1, "R11 low set");
    step(1, 64'h0000_0000_0003_4000, 52'h3F, 44'h40, 1, "R11 low clear");
    idle(2);

    // R7 / R8: accept, then stall while other fields are driven
    step(1, 64'h0000_0000_0005_5000, 52'hF0F, 44'h3_0000, 0, "R8 captured");
    for (int k = 0; k < 4; k++)
      step(1, 64'hDEAD_BEEF_0000_0000 + 64'(k << 12), {52{1'b1}}, 44'h1, 0, "R7 stall");
    step(0, '0, {52{1'b1}}, 44'h1, 1, "R7 release");
    idle(1);

    // R6 back-to-back full rate
    for (int k = 0; k < 8; k++)
      step(1, 64'(k) << 12, 52'h7, 44'h100, 1, "R6 burst");

    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [63:0] g = {$urandom, $urandom};
      logic [51:0] m = {$urandom, $urandom} & {$urandom, $urandom};
      logic [43:0] r = 44'({$urandom, $urandom}) >> ($urandom % 40);
      step(($urandom % 4) != 0, g, m, r, ($urandom % 3) != 0, "R4 R5 random");
    end
    step(0, '0, '0, '0, 1, "R6 drain");
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule